// File: doc/BRIEF.md
# Streaming Bloom Filter Pattern Tester

This block screens a continuous byte stream against a set of fixed-length patterns. It takes in one byte per clock and gives back one result bit per clock. Each result bit tells whether the window of `WIN_LEN` consecutive bytes that ends at that byte could be one of the registered patterns. A window whose bit is 0 is certainly not a pattern. A window whose bit is 1 is either a pattern or a Bloom false positive, and a later stage has to confirm it.

A polynomial rolling hash is kept over the sliding window. Each accepted byte updates it in constant work: the contribution of the byte that drops out of the window is taken away and the new byte is added. `PROBES` disjoint bit fields of the hash each address a copy of a single-bit membership array held in inferred RAM. The window is reported as a hit only when every probed bit is set.

Software computes the signatures of the patterns. It zeroes the array with a clear sweep and then sets bits one at a time through the load port, all before streaming starts. The input side uses a valid/ready handshake. `in_ready` is high at all times except during a clear sweep, so a producer never has to wait while streaming. The result side has no ready and cannot be held back: a result is presented for exactly one cycle.

Top module: `bloom_stream_tester`

## Requirements
- R1: A byte is accepted on every rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 in every cycle except during a clear sweep.
- R2: When the byte with acceptance index m (counted from 0 after reset, m >= WIN_LEN-1) is accepted at edge E, `out_valid` is 1 for exactly the one cycle that follows edge E+1. That result belongs to the window starting at index m-WIN_LEN+1.
- R3: `out_valid` stays 0 for the first WIN_LEN-1 bytes accepted after reset.
- R4: The window hash is h = sum of b_j * BASE^(WIN_LEN-1-j) mod 2^HASH_W, where b_0 is the oldest byte of the window. It is updated per byte as h' = (h - b_out*BASE^(WIN_LEN-1))*BASE + b_in. `out_hit` equals the AND, over probes p, of array bit h[p*ADDR_W +: ADDR_W], using the array contents at read time. `out_hit` is 0 whenever `out_valid` is 0.
- R5: A window equal to a pattern whose probe bits were all loaded reports `out_hit` = 1. No false negatives occur.
- R6: A cycle with `in_valid` = 0 produces no result two cycles later and does not advance the window. Bytes on either side of the gap form one continuous window.
- R7: A `clr_start` pulse while `in_ready` is 1 writes 0 to all 2^ADDR_W array bits. `in_ready` is 0 for exactly 2^ADDR_W cycles, starting in the cycle after the pulse. Every lookup after the sweep reports 0 until bits are loaded again.
- R8: When `ld_en` is 1 and no sweep is running, array bit `ld_addr` of every probe copy takes the value `ld_val` at the edge. A load while a sweep runs is ignored.
- R9: After reset, `out_valid` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take a byte (low during a clear sweep) |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Result bit present this cycle |
| out_hit | output | 1 | Window may be a registered pattern |
| ld_en | input | 1 | Write one array bit |
| ld_addr | input | ADDR_W | Array bit index to write |
| ld_val | input | 1 | Value to write |
| clr_start | input | 1 | Start a sweep that zeroes the array |

## Verification
Any corruption of the rolling hash or of the byte delay line shows at the ports. It appears as a wrong `out_hit` on a window of registered pattern bytes, at most two cycles after that window's last byte is accepted. It stays visible until a full window of new bytes has pushed the bad state out. The bench predicts every result bit from its own model of the hash and the array, so even a spurious hit on an unregistered window is caught. A fault in the window counter or in the pipeline delay moves `out_valid` by one or more cycles against the prediction. A fault in the clear sweep shows as a wrong `in_ready` low time or as surviving hits after the sweep.

// File: rtl/bf_pkg.sv
package bf_pkg;
  // base^e modulo 2^64; truncating the result gives the value modulo any 2^W, W <= 64
  function automatic longint unsigned pow_mod(input longint unsigned base, input int unsigned e);
    longint unsigned r;
    r = 64'd1;
    for (int unsigned i = 0; i < e; i++) r = r * base;
    return r;
  endfunction

  typedef enum logic {CLR_IDLE = 1'b0, CLR_RUN = 1'b1} clr_state_t;
endpackage

// File: rtl/bf_roll_hash.sv
module bf_roll_hash #(
  parameter int WIN_LEN = 8,
  parameter int HASH_W  = 24,
  parameter int BASE    = 131
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [7:0]        din,
  output logic [HASH_W-1:0] hash,
  output logic              hash_ok
);
  localparam int CW = $clog2(WIN_LEN + 1);
  localparam logic [HASH_W-1:0] DROP_MUL = HASH_W'(bf_pkg::pow_mod(longint'(BASE), WIN_LEN - 1));
  localparam logic [HASH_W-1:0] MUL      = HASH_W'(BASE);

  logic [WIN_LEN-1:0][7:0] win;
  logic [CW-1:0]           fill;
  logic [HASH_W-1:0]       drop, nxt;

  always_comb begin
    drop = HASH_W'(win[WIN_LEN-1]) * DROP_MUL;
    nxt  = (hash - drop) * MUL + HASH_W'(din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win     <= '0;
      fill    <= '0;
      hash    <= '0;
      hash_ok <= 1'b0;
    end else begin
      hash_ok <= accept && (fill >= CW'(WIN_LEN - 1));
      if (accept) begin
        win  <= {win[WIN_LEN-2:0], din};
        hash <= nxt;
        if (fill != CW'(WIN_LEN)) fill <= fill + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bf_bit_ram.sv
module bf_bit_ram #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic              wd,
  input  logic [ADDR_W-1:0] ra,
  output logic              rd
);
  localparam int DEPTH = 1 << ADDR_W;
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/bf_clear_ctrl.sv
module bf_clear_ctrl #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic [ADDR_W-1:0] addr
);
  import bf_pkg::*;
  clr_state_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= CLR_IDLE;
      addr <= '0;
    end else begin
      case (st)
        CLR_IDLE: if (start) begin
          st   <= CLR_RUN;
          addr <= '0;
        end
        CLR_RUN: begin
          addr <= addr + 1'b1;
          if (addr == {ADDR_W{1'b1}}) st <= CLR_IDLE;
        end
        default: st <= CLR_IDLE;
      endcase
    end
  end

  assign busy = (st == CLR_RUN);
endmodule

// File: rtl/bloom_stream_tester.sv
module bloom_stream_tester #(
  parameter int WIN_LEN = 8,
  parameter int HASH_W  = 24,
  parameter int ADDR_W  = 12,
  parameter int PROBES  = 2,
  parameter int BASE    = 131
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  output logic              out_hit,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              ld_val,
  input  logic              clr_start
);
  logic              accept, hash_ok, busy;
  logic [HASH_W-1:0] hash;
  logic [ADDR_W-1:0] clr_addr, wr_addr;
  logic              wr_en, wr_data;
  logic [PROBES-1:0] probe;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  bf_roll_hash #(.WIN_LEN(WIN_LEN), .HASH_W(HASH_W), .BASE(BASE)) u_hash (
    .clk(clk), .rst_n(rst_n), .accept(accept), .din(in_data),
    .hash(hash), .hash_ok(hash_ok)
  );

  bf_clear_ctrl #(.ADDR_W(ADDR_W)) u_clr (
    .clk(clk), .rst_n(rst_n), .start(clr_start && in_ready),
    .busy(busy), .addr(clr_addr)
  );

  // the sweep owns the write port; loads are dropped meanwhile
  assign wr_en   = busy || ld_en;
  assign wr_addr = busy ? clr_addr : ld_addr;
  assign wr_data = busy ? 1'b0 : ld_val;

  for (genvar gp = 0; gp < PROBES; gp++) begin : g_probe
    bf_bit_ram #(.ADDR_W(ADDR_W)) u_ram (
      .clk(clk), .we(wr_en), .wa(wr_addr), .wd(wr_data),
      .ra(hash[gp*ADDR_W +: ADDR_W]), .rd(probe[gp])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= hash_ok;
  end

  assign out_hit = out_valid && (&probe);
endmodule

// File: rtl/bloom_stream_tester_chk.sv
module bloom_stream_tester_chk #(
  parameter int WIN_LEN = 8
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_hit,
  input logic clr_start
);
  localparam int CW = $clog2(WIN_LEN + 1);
  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (in_valid && in_ready && seen != CW'(WIN_LEN)) seen <= seen + 1'b1;
  end

  AST_OUT_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready, 2)); // R2
  AST_NO_EARLY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seen == CW'(WIN_LEN))); // R3
  AST_HIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_hit); // R4
  AST_CLEAR_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_start && in_ready) |=> !in_ready); // R7
endmodule

bind bloom_stream_tester bloom_stream_tester_chk #(.WIN_LEN(WIN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_hit(out_hit), .clr_start(clr_start)
);

// File: tb/bloom_stream_tester_tb.sv
module bloom_stream_tester_tb;
  localparam int L = 8, HW = 24, AW = 12, BASE = 131;
  localparam int DEPTH = 1 << AW;
  localparam logic [63:0] P0 = "ABCDEFGH";
  localparam logic [63:0] P1 = "12345678";
  localparam logic [63:0] P2 = "bloomtst";
  // stimulus vectors: one char per slot, '_' = idle slot (in_valid low)
  localparam string STIM = "zzABCDEFGH1234_5678q_bloom__tstABCDEFGHABCDEFGHxy12345679";

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, ld_en = 0, ld_val = 0, clr_start = 0;
  logic [7:0] in_data = 0;
  logic [AW-1:0] ld_addr = 0;
  logic in_ready, out_valid, out_hit;

  int checks = 0, errors = 0;
  bit done = 0;
  bit model [DEPTH];
  logic [7:0] hist [0:1023];
  int nacc = 0, slot = 0;
  bit intact = 0;
  bit pend [0:1023], ev [0:1023], eh [0:1023], et [0:1023];
  string elbl [0:1023];

  always #10 clk = ~clk;

  bloom_stream_tester #(.WIN_LEN(L), .HASH_W(HW), .ADDR_W(AW), .PROBES(2), .BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_hit(out_hit), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_val(ld_val), .clr_start(clr_start)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [HW-1:0] sw_hash(input logic [63:0] w);
    logic [HW-1:0] h = '0;
    for (int i = 0; i < L; i++) h = HW'(h * HW'(BASE) + HW'(w[63-8*i -: 8]));
    return h;
  endfunction

  function automatic bit lookup(input logic [63:0] w);
    logic [HW-1:0] h = sw_hash(w);
    return model[h[AW-1:0]] & model[h[2*AW-1:AW]];
  endfunction

  // one slot: check the result for the slot two back, then drive this one
  task automatic step(input bit v, input logic [7:0] b);
    @(negedge clk);
    if (slot >= 2 && pend[slot-2]) begin
      chk(elbl[slot-2], out_valid, ev[slot-2]);
      if (ev[slot-2]) chk("R4", out_hit, eh[slot-2]);
      else chk("R4", out_hit, 1'b0);
      if (et[slot-2]) chk("R5", out_hit, 1'b1);
      pend[slot-2] = 0;
    end
    if (v) chk("R1", in_ready, 1'b1);
    in_valid = v;
    in_data  = b;
    pend[slot] = 1; ev[slot] = 0; eh[slot] = 0; et[slot] = 0;
    elbl[slot] = v ? "R2" : "R6";
    if (v && in_ready) begin
      hist[nacc] = b;
      nacc++;
      if (nacc >= L) begin
        logic [63:0] w = '0;
        for (int i = 0; i < L; i++) w = {w[55:0], hist[nacc-L+i]};
        ev[slot] = 1;
        eh[slot] = lookup(w);
        et[slot] = intact && (w == P0 || w == P1 || w == P2);
      end else elbl[slot] = "R3";
    end
    slot++;
  endtask

  task automatic flush();
    step(0, 8'h00);
    step(0, 8'h00);
    step(0, 8'h00);
    for (int i = 0; i < 1024; i++) pend[i] = 0;
  endtask

  task automatic ld_bit(input logic [AW-1:0] a, input logic v);
    @(negedge clk);
    ld_en = 1; ld_addr = a; ld_val = v;
    @(negedge clk);
    ld_en = 0;
    model[a] = v;
  endtask

  task automatic load_pattern(input logic [63:0] p);
    logic [HW-1:0] h = sw_hash(p);
    ld_bit(h[AW-1:0], 1'b1);
    ld_bit(h[2*AW-1:AW], 1'b1);
  endtask

  task automatic stream(input string s);
    for (int i = 0; i < s.len(); i++) begin
      if (s[i] == "_") step(0, 8'h00);
      else step(1, s[i]);
    end
    flush();
  endtask

  // clear sweep; junk bytes and a load are offered during the sweep
  task automatic do_clear(input logic [AW-1:0] junk_addr);
    int low = 0;
    @(negedge clk);
    clr_start = 1;
    @(negedge clk);
    clr_start = 0;
    chk("R7", in_ready, 1'b0);
    while (!in_ready && low < DEPTH + 10) begin
      low++;
      in_valid = (low < 4);
      in_data  = "A";
      ld_en    = (low == 2);
      ld_addr  = junk_addr;
      ld_val   = 1'b1;
      @(negedge clk);
      if (!in_ready) chk("R7", out_valid, 1'b0);
    end
    in_valid = 0; ld_en = 0;
    chk_int("R7", low, DEPTH);
    for (int i = 0; i < DEPTH; i++) model[i] = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [HW-1:0] h1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9", out_valid, 1'b0);
    chk("R9", in_ready, 1'b1);

    do_clear('0);
    load_pattern(P0);
    load_pattern(P1);
    load_pattern(P2);
    intact = 1;
    stream(STIM);                      // R2 R3 R5 R6 with gaps and overlaps

    // R8: clearing one probe bit of P1 removes its hit
    h1 = sw_hash(P1);
    intact = 0;
    ld_bit(h1[AW-1:0], 1'b0);
    stream("xx12345678yy");
    chk("R8", lookup(P1), 1'b0);
    load_pattern(P1);
    stream("12345678");

    // R7/R8: sweep empties the array; a load during the sweep is dropped
    h1 = sw_hash(P0);
    do_clear(h1[AW-1:0]);
    stream("ABCDEFGHbloomtst");
    load_pattern(P0);
    intact = 0;
    stream("qABCDEFGH");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule